// File: doc/BRIEF.md
# Constant-Pattern Binary-Field Scalar Multiplier

This block multiplies an affine point P = (x, y) over GF(2^M) by a K-bit scalar. It owns one shared point-operation unit that performs either a doubling or an addition of two affine points from a single formula. A select input chooses between the two. The controller walks the scalar from the bit below the most significant one down to bit 0. For every bit it runs a doubling of the running point and then an addition of the base point. The bit value only decides where the addition result is stored: the running point when the bit is 1, a discard register when it is 0. The sequence of operations and the run time therefore do not depend on the key.

A host drives the scalar, the point and the curve coefficient `a`, then pulses `start_i` for one cycle while the block is idle. The inputs are captured at that edge and may change afterwards. When the result is ready, `done_o` is high for one cycle and `rx_o`/`ry_o` carry the product. The outputs keep that value until the next accepted start has run to completion.

Top module: `ecsm_top`

## Requirements
- R1: Out of reset `done_o` is low and both `rx_o` and `ry_o` are zero.
- R2: A start is accepted only in the idle state. The scalar, point and coefficient are captured at that edge, and later changes on those inputs do not affect the running computation.
- R3: The result equals the scalar product computed by double-and-add-always. Field arithmetic is modulo x^M plus the low-order polynomial `POLY`. For a doubling, l = x + y/x, X = l^2 + l + a and Y = l(x + X) + X + y. For an addition of (x1, y1) and (x2, y2), l = (y1 + y2)/(x1 + x2), X = l^2 + l + x1 + x2 + a and Y = l(x1 + X) + X + y1.
- R4: A division whose denominator is zero produces a zero quotient, and the computation continues with that value.
- R5: `done_o` rises exactly 2 + (K-1)(4M+3) cycles after the cycle in which an accepted start is sampled, whatever the scalar bits are.
- R6: Each bit of the scalar below the top bit produces one doubling and then one addition. The addition result replaces the running point when the bit is 1 and goes only to the discard register when the bit is 0.
- R7: `done_o` is a one-cycle pulse, and `rx_o`/`ry_o` hold the product from the `done_o` cycle until the next product is delivered.
- R8: A start that arrives while the block is busy is ignored, including in the cycle where `done_o` is high. It captures nothing and produces no further `done_o`.
- R9: A doubling drives the unit with select 0 and the running point on both operand pairs. An addition drives it with select 1, the running point first and the base point second.
- R10: The top bit of `scalar_i` is ignored and is always treated as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request, sampled only while idle |
| scalar_i | input | K | Scalar; bit K-1 is treated as 1 |
| px_i | input | M | Base point x coordinate |
| py_i | input | M | Base point y coordinate |
| coef_a_i | input | M | Curve coefficient a |
| rx_o | output | M | Result x coordinate |
| ry_o | output | M | Result y coordinate |
| done_o | output | 1 | One-cycle pulse when the result is valid |

## Verification
The two functions that can share a cycle are the completion pulse and the start request. A start arriving in the `done_o` cycle must not be taken as a new job. The bench provokes this by raising `start_i` exactly in that cycle, with a second start issued in the middle of another run. Its clock-by-clock model then expects no further pulse and unchanged result outputs. Every run compares the pulse cycle and the held result against a behavioural double-and-add-always model. That model uses the textbook formulas and a field inverse computed by exponentiation.

// File: rtl/ecsm_pkg.sv
package ecsm_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_LOAD,
      ST_DBL,
      ST_ADD,
      ST_NEXT,
      ST_DONE
   } sm_state_t;
endpackage

// File: rtl/gf2m_sqr.sv
module gf2m_sqr #(
   parameter int          M    = 7,
   parameter logic [M-1:0] POLY = 7'h03
) (
   input  logic [M-1:0] a,
   output logic [M-1:0] y
);
   localparam int W = 2*M - 1;

   logic [W-1:0] spread;

   // squaring in a binary field interleaves zeros between the bits
   generate
      for (genvar i = 0; i < M; i++) begin : g_spread
         assign spread[2*i] = a[i];
         if (i < M-1) begin : g_gap
            assign spread[2*i+1] = 1'b0;
         end
      end
   endgenerate

   always_comb begin
      logic [W-1:0] r;
      r = spread;
      for (int j = W-1; j >= M; j--) begin
         if (r[j]) begin
            r[j] = 1'b0;
            r[j-M +: M] = r[j-M +: M] ^ POLY;
         end
      end
      y = r[M-1:0];
   end
endmodule

// File: rtl/gf2m_mul_serial.sv
module gf2m_mul_serial #(
   parameter int          M    = 7,
   parameter logic [M-1:0] POLY = 7'h03
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         go,
   input  logic [M-1:0] a,
   input  logic [M-1:0] b,
   output logic [M-1:0] p,
   output logic         rdy
);
   localparam int CW = $clog2(M+1);

   logic [M-1:0]  acc, areg, breg;
   logic [CW-1:0] cnt;
   logic          busy;

   function automatic logic [M-1:0] xtime(input logic [M-1:0] v);
      return {v[M-2:0], 1'b0} ^ (v[M-1] ? POLY : '0);
   endfunction

   // most significant multiplier bit first, one bit per cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc  <= '0;
         areg <= '0;
         breg <= '0;
         cnt  <= '0;
         busy <= 1'b0;
         rdy  <= 1'b0;
      end else begin
         rdy <= 1'b0;
         if (go) begin
            acc  <= b[M-1] ? a : '0;
            areg <= a;
            breg <= {b[M-2:0], 1'b0};
            cnt  <= CW'(M-1);
            busy <= 1'b1;
         end else if (busy) begin
            acc  <= xtime(acc) ^ (breg[M-1] ? areg : '0);
            breg <= {breg[M-2:0], 1'b0};
            cnt  <= cnt - CW'(1);
            if (cnt == CW'(1)) begin
               busy <= 1'b0;
               rdy  <= 1'b1;
            end
         end
      end
   end

   assign p = acc;
endmodule

// File: rtl/gf2m_div_fermat.sv
module gf2m_div_fermat #(
   parameter int          M    = 7,
   parameter logic [M-1:0] POLY = 7'h03
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         go,
   input  logic [M-1:0] num,
   input  logic [M-1:0] den,
   output logic [M-1:0] q,
   output logic         rdy
);
   localparam int CW = $clog2(M+1);

   logic [M-1:0]  acc, pw;
   logic [CW-1:0] cnt;
   logic          busy;
   logic [M-1:0]  den2, den4;

   function automatic logic [M-1:0] fmul(input logic [M-1:0] x, input logic [M-1:0] z);
      logic [M-1:0] r;
      r = '0;
      for (int i = M-1; i >= 0; i--) begin
         r = {r[M-2:0], 1'b0} ^ (r[M-1] ? POLY : '0);
         if (z[i]) r = r ^ x;
      end
      return r;
   endfunction

   assign den2 = fmul(den, den);
   assign den4 = fmul(den2, den2);

   // num * den^(2^M-2): product of den^(2^i), i = 1..M-1, one factor per cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc  <= '0;
         pw   <= '0;
         cnt  <= '0;
         busy <= 1'b0;
         rdy  <= 1'b0;
      end else begin
         rdy <= 1'b0;
         if (go) begin
            acc  <= fmul(num, den2);
            pw   <= den4;
            cnt  <= CW'(M-2);
            busy <= 1'b1;
         end else if (busy) begin
            acc <= fmul(acc, pw);
            pw  <= fmul(pw, pw);
            cnt <= cnt - CW'(1);
            if (cnt == CW'(1)) begin
               busy <= 1'b0;
               rdy  <= 1'b1;
            end
         end
      end
   end

   assign q = acc;
endmodule

// File: rtl/ec_unified_pt.sv
module ec_unified_pt #(
   parameter int          M    = 7,
   parameter logic [M-1:0] POLY = 7'h03
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         go,
   input  logic         add_i,
   input  logic [M-1:0] xp,
   input  logic [M-1:0] yp,
   input  logic [M-1:0] xq,
   input  logic [M-1:0] yq,
   input  logic [M-1:0] a,
   output logic [M-1:0] xr,
   output logic [M-1:0] yr,
   output logic         done
);
   logic [M-1:0] num, den, quo, lam, lam_sq, xnew, xhold, prod;
   logic         div_rdy, mul_rdy;

   // operand masking by the select bit gives one data path for both operations
   assign num = (add_i ? yq : '0) ^ yp;
   assign den = (add_i ? xq : '0) ^ xp;

   gf2m_div_fermat #(.M(M), .POLY(POLY)) u_div (
      .clk(clk), .rst_n(rst_n), .go(go), .num(num), .den(den),
      .q(quo), .rdy(div_rdy)
   );

   assign lam = quo ^ (add_i ? '0 : xp);

   gf2m_sqr #(.M(M), .POLY(POLY)) u_sqr (.a(lam), .y(lam_sq));

   assign xnew = lam_sq ^ lam ^ (add_i ? (xp ^ xq) : '0) ^ a;

   gf2m_mul_serial #(.M(M), .POLY(POLY)) u_mul (
      .clk(clk), .rst_n(rst_n), .go(div_rdy), .a(lam), .b(xp ^ xnew),
      .p(prod), .rdy(mul_rdy)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         xhold <= '0;
         xr    <= '0;
         yr    <= '0;
         done  <= 1'b0;
      end else begin
         done <= 1'b0;
         if (div_rdy) xhold <= xnew;
         if (mul_rdy) begin
            xr   <= xhold;
            yr   <= prod ^ xhold ^ yp;
            done <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/ecsm_top.sv
module ecsm_top
   import ecsm_pkg::*;
#(
   parameter int          M    = 7,
   parameter int          K    = 8,
   parameter logic [M-1:0] POLY = 7'h03
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start_i,
   input  logic [K-1:0] scalar_i,
   input  logic [M-1:0] px_i,
   input  logic [M-1:0] py_i,
   input  logic [M-1:0] coef_a_i,
   output logic [M-1:0] rx_o,
   output logic [M-1:0] ry_o,
   output logic         done_o
);
   localparam int IW = (K > 2) ? $clog2(K) : 1;

   generate
      if (M < 3) begin : g_bad_m
         $error("ecsm_top: M must be at least 3");
      end
      if (K < 2) begin : g_bad_k
         $error("ecsm_top: K must be at least 2");
      end
   endgenerate

   sm_state_t    st;
   logic [K-1:0] key;
   logic [IW-1:0] idx;
   logic [M-1:0] bx, by, ca, accx, accy, dmx, dmy;
   logic         pend;
   logic         pa_go, pa_add, pa_done, cur_bit, busy, in_add;
   logic [M-1:0] pa_xq, pa_yq, pa_xr, pa_yr;

   assign in_add  = (st == ST_ADD);
   assign busy    = (st != ST_IDLE);
   assign cur_bit = key[idx];
   assign pa_go   = ((st == ST_DBL) || (st == ST_ADD)) && !pend;
   assign pa_add  = in_add;
   assign pa_xq   = pa_add ? bx : accx;
   assign pa_yq   = pa_add ? by : accy;

   ec_unified_pt #(.M(M), .POLY(POLY)) u_pt (
      .clk(clk), .rst_n(rst_n), .go(pa_go), .add_i(pa_add),
      .xp(accx), .yp(accy), .xq(pa_xq), .yq(pa_yq), .a(ca),
      .xr(pa_xr), .yr(pa_yr), .done(pa_done)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st   <= ST_IDLE;
         key  <= '0;
         idx  <= '0;
         bx   <= '0;
         by   <= '0;
         ca   <= '0;
         accx <= '0;
         accy <= '0;
         dmx  <= '0;
         dmy  <= '0;
         rx_o <= '0;
         ry_o <= '0;
         pend <= 1'b0;
      end else begin
         if (pa_go) pend <= 1'b1;
         unique case (st)
            ST_IDLE: if (start_i) begin
               key <= scalar_i | (K'(1) << (K-1));
               bx  <= px_i;
               by  <= py_i;
               ca  <= coef_a_i;
               st  <= ST_LOAD;
            end
            ST_LOAD: begin
               accx <= bx;
               accy <= by;
               idx  <= IW'(K-2);
               st   <= ST_DBL;
            end
            ST_DBL: if (pa_done) begin
               accx <= pa_xr;
               accy <= pa_yr;
               pend <= 1'b0;
               st   <= ST_ADD;
            end
            ST_ADD: if (pa_done) begin
               if (cur_bit) begin
                  accx <= pa_xr;
                  accy <= pa_yr;
               end else begin
                  dmx <= pa_xr;
                  dmy <= pa_yr;
               end
               pend <= 1'b0;
               st   <= ST_NEXT;
            end
            ST_NEXT: if (idx == '0) begin
               rx_o <= accx;
               ry_o <= accy;
               st   <= ST_DONE;
            end else begin
               idx <= idx - IW'(1);
               st  <= ST_DBL;
            end
            ST_DONE: st <= ST_IDLE;
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign done_o = (st == ST_DONE);
endmodule

// File: rtl/ecsm_chk.sv
module ecsm_chk #(
   parameter int M = 7
) (
   input logic         clk,
   input logic         rst_n,
   input logic         start_i,
   input logic         busy,
   input logic         done_o,
   input logic         pa_go,
   input logic         pa_add,
   input logic         pa_done,
   input logic         in_add,
   input logic         cur_bit,
   input logic [M-1:0] pa_xp,
   input logic [M-1:0] pa_yp,
   input logic [M-1:0] pa_xq,
   input logic [M-1:0] pa_yq,
   input logic [M-1:0] base_x,
   input logic [M-1:0] base_y,
   input logic [M-1:0] dum_x,
   input logic [M-1:0] dum_y
);
   logic last_add;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) last_add <= 1'b1;
      else if (pa_go) last_add <= pa_add;
   end

   // R7
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R9
   dbl_operands_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pa_go && !pa_add) |-> (pa_xq == pa_xp) && (pa_yq == pa_yp));

   // R9
   add_operands_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pa_go && pa_add) |-> (pa_xq == base_x) && (pa_yq == base_y));

   // R6
   op_alternate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pa_go |-> (pa_add != last_add));

   // R6
   dummy_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pa_done && in_add && cur_bit) |=> $stable(dum_x) && $stable(dum_y));

   // R6
   acc_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pa_done && in_add && !cur_bit) |=> $stable(pa_xp) && $stable(pa_yp));

   // R8
   busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && busy) |=> $stable(base_x) && $stable(base_y));
endmodule

bind ecsm_top ecsm_chk #(.M(M)) u_chk (
   .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy(busy), .done_o(done_o),
   .pa_go(pa_go), .pa_add(pa_add), .pa_done(pa_done), .in_add(in_add),
   .cur_bit(cur_bit), .pa_xp(accx), .pa_yp(accy), .pa_xq(pa_xq), .pa_yq(pa_yq),
   .base_x(bx), .base_y(by), .dum_x(dmx), .dum_y(dmy)
);

// File: tb/ecsm_top_tb.sv
`timescale 1ns/1ps
module ecsm_top_tb;
   localparam int M     = 7;
   localparam int K     = 8;
   localparam int POLYF = 'h83;
   localparam int T     = 2 + (K-1)*(4*M+3);

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start_i = 1'b0;
   logic [K-1:0] scalar_i = '0;
   logic [M-1:0] px_i = '0, py_i = '0, coef_a_i = '0;
   logic [M-1:0] rx_o, ry_o;
   logic         done_o;

   int    total = 0, bad = 0, ec = 0, exp_edge = -10;
   int    hx = 0, hy = 0, pend_x = 0, pend_y = 0;
   bit    mon_on = 1'b0;
   string tag = "R1";

   always #2.5 clk = ~clk;

   ecsm_top #(.M(M), .K(K), .POLY(7'h03)) u_dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .scalar_i(scalar_i),
      .px_i(px_i), .py_i(py_i), .coef_a_i(coef_a_i),
      .rx_o(rx_o), .ry_o(ry_o), .done_o(done_o)
   );

   always @(posedge clk) ec <= ec + 1;

   task automatic chk(input bit ok, input string req, input int act, input int expv);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h", req, act, expv);
      end
   endtask

   function automatic int gmul(input int x, input int z);
      int r = 0;
      for (int i = M-1; i >= 0; i--) begin
         r = r << 1;
         if (((r >> M) & 1) != 0) r = r ^ POLYF;
         if (((z >> i) & 1) != 0) r = r ^ x;
      end
      return r;
   endfunction

   function automatic int gdiv(input int n, input int d);
      int r = 1;
      for (int i = 0; i < (1 << M) - 2; i++) r = gmul(r, d);
      return gmul(n, r);
   endfunction

   task automatic pdbl(inout int x, inout int y, input int a);
      int l = x ^ gdiv(y, x);
      int nx = gmul(l, l) ^ l ^ a;
      y = gmul(l, x ^ nx) ^ nx ^ y;
      x = nx;
   endtask

   task automatic padd(input int x1, input int y1, input int x2, input int y2,
                       input int a, output int ox, output int oy);
      int l = gdiv(y1 ^ y2, x1 ^ x2);
      ox = gmul(l, l) ^ l ^ x1 ^ x2 ^ a;
      oy = gmul(l, x1 ^ ox) ^ ox ^ y1;
   endtask

   // R10: the top scalar bit is never consulted; the walk starts at P
   task automatic smul(input logic [K-1:0] d, input int x, input int y, input int a,
                       output int ox, output int oy);
      int ax = x, ay = y, tx, ty;
      for (int i = K-2; i >= 0; i--) begin
         pdbl(ax, ay, a);
         padd(ax, ay, x, y, a, tx, ty);
         if (d[i]) begin ax = tx; ay = ty; end
      end
      ox = ax;
      oy = ay;
   endtask

   // clock-by-clock comparison of the pulse and the held result
   always @(negedge clk) begin
      if (mon_on) begin
         if (ec == exp_edge) begin hx = pend_x; hy = pend_y; end
         chk(done_o == (ec == exp_edge), {"R5 ", tag}, int'(done_o), int'(ec == exp_edge));
         chk(int'(rx_o) == hx, {"R7 x ", tag}, int'(rx_o), hx);
         chk(int'(ry_o) == hy, {"R7 y ", tag}, int'(ry_o), hy);
      end
   end

   task automatic run(input logic [K-1:0] d, input int x, input int y, input int a,
                      input string t, input int mid_start, input bit on_done);
      int ex, ey;
      smul(d, x, y, a, ex, ey);
      @(negedge clk);
      tag = t;
      scalar_i = d; px_i = M'(x); py_i = M'(y); coef_a_i = M'(a);
      start_i = 1'b1;
      pend_x = ex; pend_y = ey;
      exp_edge = ec + T;
      @(negedge clk);
      start_i = 1'b0;
      // R2: scramble the inputs once captured
      scalar_i = ~d; px_i = ~M'(x); py_i = M'(y) ^ 7'h55; coef_a_i = ~M'(a);
      if (mid_start > 0) begin
         repeat (mid_start) @(negedge clk);
         start_i = 1'b1;
         @(negedge clk);
         start_i = 1'b0;
      end
      while (ec <= exp_edge) begin
         start_i = on_done && (ec == exp_edge);
         @(negedge clk);
      end
      start_i = 1'b0;
      chk(int'(rx_o) == ex, {"R3 ", t}, int'(rx_o), ex);
      chk(int'(ry_o) == ey, {"R3 ", t}, int'(ry_o), ey);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int sx, sy;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1
      chk(done_o == 1'b0, "R1 done", int'(done_o), 0);
      chk(rx_o == '0 && ry_o == '0, "R1 result", int'(rx_o), 0);
      mon_on = 1'b1;
      // R3 and R9: mixed bit pattern
      run(8'hB5, 'h35, 'h1A, 'h01, "R3", 0, 1'b0);
      sx = int'(rx_o); sy = int'(ry_o);
      // R6: all ones and all zeros below the top bit take the same time
      run(8'hFF, 'h35, 'h1A, 'h01, "R6", 0, 1'b0);
      run(8'h80, 'h21, 'h4C, 'h00, "R6", 0, 1'b0);
      // R10: top bit clear gives the same product as top bit set
      run(8'h35, 'h35, 'h1A, 'h01, "R10", 0, 1'b0);
      chk(int'(rx_o) == sx && int'(ry_o) == sy, "R10 top bit", int'(rx_o), sx);
      // R4: base x of zero forces zero denominators
      run(8'hA3, 'h00, 'h11, 'h05, "R4", 0, 1'b0);
      // R8: start in the middle of a run, then start in the done cycle
      run(8'h5C, 'h47, 'h2B, 'h03, "R8", 40, 1'b0);
      run(8'h9E, 'h12, 'h6D, 'h02, "R8", 0, 1'b1);
      sx = int'(rx_o);
      repeat (T + 20) @(negedge clk);
      chk(int'(rx_o) == sx, "R8 done-cycle start", int'(rx_o), sx);
      // R2: a fresh start after idle is accepted
      run(8'hC1, 'h7F, 'h03, 'h04, "R2", 0, 1'b0);
      mon_on = 1'b0;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule